// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers interrupt requests for a small processor. It has two local groups of eight level-sensitive sources. Each group has a pending-status view and an enable mask, and each group drives one interrupt line toward the CPU. A third group of eight sources, the mappable group, has no CPU line of its own. It is filtered by two independent enable masks. The OR of each filtered result is folded into a fixed bit of a local group: the first into local group 0 at bit 7, the second into local group 1 at bit 3.

Two sticky timer flags latch one-cycle pulses from external timers. They stay set until software writes a clear register that is write-only. Every source passes through a two-flop synchroniser. Software reaches the masks and status views through a word-addressed 32-bit register port. Reads return data in the same cycle, and writes take effect at the next clock edge.

Top module: `irq_agg_top`

## Requirements
- R1: While reset is active and right after it, every mask register is zero, both CPU lines are low and both timer flags are clear.
- R2: Each status register reads back the raw pending bits of its sources, whatever the mask holds. A source level change becomes visible after two rising clock edges.
- R3: CPU line g is high exactly when its local status AND its local mask is non-zero.
- R4: The register map uses word addresses: 0 local-0 status, 1 local-0 mask, 2 local-1 status, 3 local-1 mask, 4 mappable status, 5 mappable mask A, 6 mappable mask B, 7 timer clear. Register contents sit in data bits 7:0, and the upper read bits are zero.
- R5: The OR of (mappable status AND mask A) is ORed into bit 7 of the local-0 status.
- R6: The OR of (mappable status AND mask B) is ORed into bit 3 of the local-1 status.
- R7: Writes to addresses 0, 2 and 4 change no register and no output.
- R8: A one-cycle timer pulse on bit i sets timer flag i at the next edge, and the flag stays set until it is cleared.
- R9: A write to address 7 clears timer flag 0 when data bit 0 is set, and timer flag 1 when data bit 1 is set. Flags whose bits are zero keep their value.
- R10: If a timer pulse and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R11: Read data is zero when no read is strobed, and a read of address 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_grp0_i | input | 8 | Local group 0 source levels |
| src_grp1_i | input | 8 | Local group 1 source levels |
| src_map_i | input | 8 | Mappable group source levels |
| tmr_pulse_i | input | 2 | One-cycle timer event pulses |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| cpu_irq_o | output | 2 | CPU interrupt lines, one per local group |
| tmr_irq_o | output | 2 | Sticky timer flags |

## Verification
A corrupted mask register shows up on a CPU line as soon as it is written. It also shows up in the very next read of that address, so each mask write is followed by a port read and a line check in the same low phase. A wrong cascade path appears only in bit 7 of local-0 status or bit 3 of local-1 status, two edges after the mappable source moves. The bench therefore reads those status words after exactly that latency, under several mask A and mask B settings. A fault in the timer flags shows on the tmr_irq_o output one edge after the pulse or clear that caused it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int GRP_W  = 8;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_L0_STAT = 3'd0,
        RA_L0_MASK = 3'd1,
        RA_L1_STAT = 3'd2,
        RA_L1_MASK = 3'd3,
        RA_MP_STAT = 3'd4,
        RA_MP_MSKA = 3'd5,
        RA_MP_MSKB = 3'd6,  // must stay one word above mask A
        RA_TMR_CLR = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [GRP_W-1:0] l0_mask;
        logic [GRP_W-1:0] l1_mask;
        logic [GRP_W-1:0] mp_mska;
        logic [GRP_W-1:0] mp_mskb;
    } mask_state_t;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_agg_tflags.sv
module irq_agg_tflags #(
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_TMR-1:0] set_i,
    input  logic [N_TMR-1:0] clr_i,
    output logic [N_TMR-1:0] flag_o
);
    logic [N_TMR-1:0] flag_d, flag_q;

    // set is applied after clear, so a same-cycle pair leaves the flag set
    always_comb begin
        flag_d = (flag_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int N_TMR       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CASC0_BIT   = 7,
    parameter int CASC1_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_W-1:0]  src_grp0_i,
    input  logic [GRP_W-1:0]  src_grp1_i,
    input  logic [GRP_W-1:0]  src_map_i,
    input  logic [N_TMR-1:0]  tmr_pulse_i,
    input  logic              reg_valid_i,
    input  logic              reg_write_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [1:0]        cpu_irq_o,
    output logic [N_TMR-1:0]  tmr_irq_o
);
    localparam int SRC_W = 3 * GRP_W;

    logic [SRC_W-1:0] src_sync;
    logic [GRP_W-1:0] g0_raw, g1_raw, mp_raw;
    logic [GRP_W-1:0] l0_stat, l1_stat;
    logic             casc_a, casc_b;
    logic             wr_en, rd_en;
    logic [N_TMR-1:0] tmr_clr;
    mask_state_t      st_d, st_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:GRP_W];

    irq_agg_sync #(.WIDTH(SRC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({src_map_i, src_grp1_i, src_grp0_i}),
        .sync_o  (src_sync)
    );

    assign g0_raw = src_sync[GRP_W-1:0];
    assign g1_raw = src_sync[2*GRP_W-1:GRP_W];
    assign mp_raw = src_sync[3*GRP_W-1:2*GRP_W];

    // cascade of the filtered mappable group into the local groups
    assign casc_a  = |(mp_raw & st_q.mp_mska);
    assign casc_b  = |(mp_raw & st_q.mp_mskb);
    assign l0_stat = g0_raw | (GRP_W'(casc_a) << CASC0_BIT);
    assign l1_stat = g1_raw | (GRP_W'(casc_b) << CASC1_BIT);

    assign wr_en = reg_valid_i &&  reg_write_i;
    assign rd_en = reg_valid_i && !reg_write_i;

    always_comb begin
        st_d    = st_q;
        tmr_clr = '0;
        if (wr_en) begin
            case (reg_addr_e'(reg_addr_i))
                RA_L0_MASK: st_d.l0_mask = reg_wdata_i[GRP_W-1:0];
                RA_L1_MASK: st_d.l1_mask = reg_wdata_i[GRP_W-1:0];
                RA_MP_MSKA: st_d.mp_mska = reg_wdata_i[GRP_W-1:0];
                RA_MP_MSKB: st_d.mp_mskb = reg_wdata_i[GRP_W-1:0];
                RA_TMR_CLR: tmr_clr      = reg_wdata_i[N_TMR-1:0];
                default:    ;  // status views are read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (rd_en) begin
            case (reg_addr_e'(reg_addr_i))
                RA_L0_STAT: reg_rdata_o = DATA_W'(l0_stat);
                RA_L0_MASK: reg_rdata_o = DATA_W'(st_q.l0_mask);
                RA_L1_STAT: reg_rdata_o = DATA_W'(l1_stat);
                RA_L1_MASK: reg_rdata_o = DATA_W'(st_q.l1_mask);
                RA_MP_STAT: reg_rdata_o = DATA_W'(mp_raw);
                RA_MP_MSKA: reg_rdata_o = DATA_W'(st_q.mp_mska);
                RA_MP_MSKB: reg_rdata_o = DATA_W'(st_q.mp_mskb);
                default:    reg_rdata_o = '0;
            endcase
        end
    end

    assign cpu_irq_o[0] = |(l0_stat & st_q.l0_mask);
    assign cpu_irq_o[1] = |(l1_stat & st_q.l1_mask);

    irq_agg_tflags #(.N_TMR(N_TMR)) tflags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tmr_pulse_i),
        .clr_i  (tmr_clr),
        .flag_o (tmr_irq_o)
    );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_TMR  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TMR-1:0]  tmr_pulse_i,
    input logic              reg_valid_i,
    input logic              reg_write_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic [1:0]        cpu_irq_o,
    input logic [N_TMR-1:0]  tmr_irq_o
);
    logic             clr_wr;
    logic             unused_wd;

    assign clr_wr    = reg_valid_i && reg_write_i && (reg_addr_i == RA_TMR_CLR);
    assign unused_wd = ^reg_wdata_i[DATA_W-1:N_TMR];

    // R1
    always_comb begin
        if (rst_n == 1'b0) begin
            a_r1_quiet_in_reset: assert (cpu_irq_o == '0 && tmr_irq_o == '0);
        end
    end

    // R11
    a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid_i && !reg_write_i) |-> reg_rdata_o == '0);

    a_r11_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid_i && !reg_write_i && reg_addr_i == RA_TMR_CLR) |-> reg_rdata_o == '0);

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        // R8, R10
        a_r8_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_pulse_i[i] |=> tmr_irq_o[i]);
        // R8
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (tmr_irq_o[i] && !(clr_wr && reg_wdata_i[i])) |=> tmr_irq_o[i]);
        // R9
        a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && reg_wdata_i[i] && !tmr_pulse_i[i]) |=> !tmr_irq_o[i]);
    end
endmodule

bind irq_agg_top irq_agg_chk #(.DATA_W(DATA_W), .N_TMR(N_TMR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_pulse_i (tmr_pulse_i),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cpu_irq_o   (cpu_irq_o),
    .tmr_irq_o   (tmr_irq_o)
);

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src0 = '0, src1 = '0, srcm = '0;
    logic [1:0]  tpulse = '0;
    logic        valid = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  cpu_irq, tmr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_agg_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_grp0_i(src0), .src_grp1_i(src1), .src_map_i(srcm),
        .tmr_pulse_i(tpulse),
        .reg_valid_i(valid), .reg_write_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .cpu_irq_o(cpu_irq), .tmr_irq_o(tmr_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        valid = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk("R1 cpu_irq", 32'(cpu_irq), 0);
        chk("R1 tmr_irq", 32'(tmr_irq), 0);
        reg_rd(3'd1, d); chk("R1 l0 mask", d, 0);
        reg_rd(3'd6, d); chk("R1 mask B", d, 0);
        #1 chk("R11 idle rdata", rdata, 0);
    endtask

    task automatic t_raw_and_mask();
        logic [31:0] d;
        @(negedge clk); src0 = 8'h5A; src1 = 8'hC3;
        settle();
        reg_rd(3'd0, d); chk("R2 l0 raw", d, 32'h5A);
        reg_rd(3'd2, d); chk("R2 l1 raw", d, 32'hC3);
        chk("R3 no irq with zero mask", 32'(cpu_irq), 0);
        reg_wr(3'd1, 32'h0000_0001);
        chk("R3 disjoint mask", 32'(cpu_irq[0]), 0);
        reg_wr(3'd1, 32'hFFFF_FF10);
        chk("R3 overlapping mask", 32'(cpu_irq[0]), 1);
        reg_rd(3'd1, d); chk("R4 mask readback upper zero", d, 32'h10);
        reg_rd(3'd0, d); chk("R2 status unmasked", d, 32'h5A);
        reg_wr(3'd1, 32'h0);
    endtask

    task automatic t_cascade();
        logic [31:0] d;
        @(negedge clk); src0 = 8'h00; srcm = 8'h21;
        settle();
        reg_rd(3'd4, d); chk("R4 map status", d, 32'h21);
        reg_rd(3'd0, d); chk("R5 no cascade with mask A zero", d, 32'h00);
        reg_wr(3'd1, 32'h80);
        reg_wr(3'd5, 32'h01);
        reg_rd(3'd0, d); chk("R5 cascade bit7", d, 32'h80);
        chk("R5 irq0 from cascade", 32'(cpu_irq[0]), 1);
        reg_wr(3'd5, 32'h02);
        reg_rd(3'd0, d); chk("R5 cascade off", d, 32'h00);
        chk("R5 irq0 low", 32'(cpu_irq[0]), 0);
        reg_wr(3'd6, 32'h20);
        reg_rd(3'd2, d); chk("R6 cascade bit3", d, 32'hCB);
        reg_rd(3'd5, d); chk("R4 mask A separate", d, 32'h02);
        chk("R6 irq1 masked", 32'(cpu_irq[1]), 0);
        reg_wr(3'd3, 32'h08);
        chk("R6 irq1 from cascade", 32'(cpu_irq[1]), 1);
    endtask

    task automatic t_status_ro();
        logic [31:0] d;
        reg_wr(3'd0, 32'hFF);
        reg_wr(3'd2, 32'h00);
        reg_wr(3'd4, 32'hFF);
        reg_rd(3'd0, d); chk("R7 l0 status kept", d, 32'h00);
        reg_rd(3'd2, d); chk("R7 l1 status kept", d, 32'hCB);
        reg_rd(3'd4, d); chk("R7 map status kept", d, 32'h21);
        chk("R7 lines unchanged", 32'(cpu_irq), 32'h2);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        @(negedge clk); tpulse = 2'b01;
        @(negedge clk); tpulse = 2'b00;
        chk("R8 flag0 set", 32'(tmr_irq), 32'h1);
        repeat (3) @(negedge clk);
        chk("R8 flag0 sticky", 32'(tmr_irq), 32'h1);
        reg_wr(3'd7, 32'h2);
        chk("R9 other bit keeps flag0", 32'(tmr_irq), 32'h1);
        reg_wr(3'd7, 32'h1);
        chk("R9 flag0 cleared", 32'(tmr_irq), 32'h0);
        @(negedge clk); tpulse = 2'b11;
        @(negedge clk); tpulse = 2'b00;
        chk("R8 both set", 32'(tmr_irq), 32'h3);
        reg_rd(3'd7, d); chk("R11 clear reg reads zero", d, 0);
        reg_wr(3'd7, 32'h3);
        chk("R9 both cleared", 32'(tmr_irq), 32'h0);
        @(negedge clk);
        tpulse = 2'b10; valid = 1'b1; wr = 1'b1; addr = 3'd7; wdata = 32'h2;
        @(negedge clk);
        tpulse = 2'b00; valid = 1'b0; wr = 1'b0; wdata = '0;
        chk("R10 set wins", 32'(tmr_irq), 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 lines low in reset", 32'({cpu_irq, tmr_irq}), 0);
        rst_n = 1'b1;
        t_reset();
        t_raw_and_mask();
        t_cascade();
        t_status_ro();
        t_timer();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule